// File: doc/BRIEF.md
# Transmit Buffer Replay Controller

This block sits between a DMA stream and a digital-to-analog converter interface. A DMA loads a data set into on-chip storage through an AXI4-Stream slave. Once a synchronization event occurs, the controller plays the stored beats back to the converter as a continuous AXI4-Stream master. Playback either repeats the stored set without end or makes a single pass and stops.

Loading is opened by a request/acknowledge handshake. The start of playback is chosen by a 2-bit mode: the end of the DMA packet, an external trigger, or a one-cycle software pulse. Once synchronized, the DMA side is held busy. A bypass control connects the input stream straight to the output. A synchronous soft reset returns the controller to idle. The FSM state is visible on an 8-bit debug output. The storage write strobes are also brought out, so a neighbour can observe what was stored.

Top module: `tx_replay_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `init_ack_o`, `s_ready_o`, `m_valid_o` and `empty_err_o` are all low.
- R2: When `init_req_i` is high in idle (0) or done (5), the state becomes 1 (prepare) on the next edge and 2 (loading) one edge later. `init_ack_o` is high only in states 2 (loading) and 3 (awaiting sync).
- R3: In state 2, each accepted input beat drives `wr_en_o` high with `wr_data_o` equal to the beat data. `wr_addr_o` starts at 0 and rises by one per beat. `wr_last_o` is high on a beat that carries `s_last_i` and on a beat written to the highest address.
- R4: In mode 0 (automatic), the edge that accepts the final beat moves the state to 4 (playing).
- R5: In mode 1 the final beat moves the state to 3 and a `hw_sync_i` pulse starts playback. In mode 2 the final beat moves the state to 3 and an `sw_sync_i` pulse starts playback. The sync input of the other mode is ignored. Mode 3 never starts playback.
- R6: When a sync pulse arrives while beats are still loading, the beat offered in that cycle is refused. Playback then covers only the beats already written.
- R7: In states 3, 4 and 5, `s_ready_o` stays low while bypass is off.
- R8: In state 4 with `oneshot_i` low, `m_valid_o` stays high. `m_data_o` walks the stored beats in address order from 0 and wraps to 0 after the last one. It advances only on a cycle with `m_ready_i` high.
- R9: If `oneshot_i` is high when the last stored beat is taken, the state becomes 5 (done) and `m_valid_o` goes low.
- R10: `empty_err_o` sets when `m_ready_i` is high in state 4 with no beats stored. It stays set until reset or soft reset.
- R11: With `bypass_i` high, `m_valid_o` follows `s_valid_i`, `m_data_o` follows `s_data_i` and `s_ready_o` follows `m_ready_i`. Nothing is written and the state does not change.
- R12: `soft_rst_i` returns the state to 0 on the next edge and clears `empty_err_o`. The next load writes from address 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to idle |
| init_req_i | input | 1 | Request to open a load |
| init_ack_o | output | 1 | Load window open |
| sync_mode_i | input | 2 | 0 auto, 1 hardware, 2 software, 3 none |
| hw_sync_i | input | 1 | External start trigger |
| sw_sync_i | input | 1 | Software start pulse |
| oneshot_i | input | 1 | Stop after one pass |
| bypass_i | input | 1 | Route input stream straight to output |
| s_valid_i | input | 1 | DMA beat valid |
| s_data_i | input | DATA_W | DMA beat data |
| s_last_i | input | 1 | DMA final beat |
| s_ready_o | output | 1 | Beat accepted when high with valid |
| m_valid_o | output | 1 | Converter stream valid |
| m_data_o | output | DATA_W | Converter stream data |
| m_ready_i | input | 1 | Converter takes a beat |
| wr_en_o | output | 1 | Storage write strobe |
| wr_addr_o | output | ADDR_W | Storage write address |
| wr_data_o | output | DATA_W | Storage write data |
| wr_last_o | output | 1 | Final write of the load |
| empty_err_o | output | 1 | Sticky read-while-empty flag |
| state_o | output | 8 | FSM state code |

## Verification
The bench first checks the wrap point of cyclic replay across several lengths, including a single beat. A design off by one would repeat or skip a beat at the seam. It then fills the storage completely with no last marker, where a missing full-buffer end would wrap the write pointer and overwrite beat 0. A trigger arriving mid-load must refuse the beat offered in that cycle, or the replay would gain a foreign beat. The bench also checks that the wrong sync input and mode 3 leave the controller waiting, that the empty flag holds after the request goes away, and that the write address restarts at 0 after a soft reset.

// File: rtl/tx_replay_pkg.sv
package tx_replay_pkg;
  typedef enum logic [7:0] {
    ST_IDLE    = 8'd0,
    ST_PREP    = 8'd1,
    ST_LOAD    = 8'd2,
    ST_WSYNC   = 8'd3,
    ST_PLAY    = 8'd4,
    ST_DONE    = 8'd5
  } state_e;

  localparam logic [1:0] SYNC_AUTO = 2'd0;
  localparam logic [1:0] SYNC_HW   = 2'd1;
  localparam logic [1:0] SYNC_SW   = 2'd2;
endpackage

// File: rtl/tx_replay_mem.sv
module tx_replay_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_replay_sync.sv
module tx_replay_sync
  import tx_replay_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       hw_sync_i,
  input  logic       sw_sync_i,
  output logic       auto_o,
  output logic       sync_o
);
  always_comb begin
    auto_o = 1'b0;
    sync_o = 1'b0;
    unique case (mode_i)
      SYNC_AUTO: auto_o = 1'b1;
      SYNC_HW:   sync_o = hw_sync_i;
      SYNC_SW:   sync_o = sw_sync_i;
      default:   ;
    endcase
  end
endmodule

// File: rtl/tx_replay_fsm.sv
module tx_replay_fsm
  import tx_replay_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              hold_i,
  input  logic              init_req_i,
  input  logic              auto_i,
  input  logic              sync_i,
  input  logic              oneshot_i,
  input  logic              beat_valid_i,
  input  logic              beat_last_i,
  input  logic              rd_ready_i,
  output logic              load_ready_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_last_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              play_valid_o,
  output logic              init_ack_o,
  output logic              empty_err_o,
  output logic [7:0]        state_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q, len_q;
  logic              have_q, err_q;
  logic              accept, at_top, fire, at_end;

  assign load_ready_o = !hold_i && state_q == ST_LOAD && !sync_i;
  assign accept       = load_ready_o && beat_valid_i;
  assign at_top       = &wr_ptr_q;
  assign wr_en_o      = accept;
  assign wr_last_o    = accept && (beat_last_i || at_top);
  assign wr_addr_o    = wr_ptr_q;
  assign rd_addr_o    = rd_ptr_q;
  assign play_valid_o = !hold_i && state_q == ST_PLAY && have_q;
  assign fire         = play_valid_o && rd_ready_i;
  assign at_end       = rd_ptr_q == len_q;
  assign init_ack_o   = state_q == ST_LOAD || state_q == ST_WSYNC;
  assign empty_err_o  = err_q;
  assign state_o      = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      len_q    <= '0;
      have_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (soft_rst_i) begin
      state_q  <= ST_IDLE;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      len_q    <= '0;
      have_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (!hold_i) begin
      if (state_q == ST_PLAY && !have_q && rd_ready_i) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE, ST_DONE: if (init_req_i) state_q <= ST_PREP;
        ST_PREP: begin
          wr_ptr_q <= '0;
          have_q   <= 1'b0;
          state_q  <= ST_LOAD;
        end
        ST_LOAD: begin
          if (accept) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
            len_q    <= wr_ptr_q;
            have_q   <= 1'b1;
            if (wr_last_o) begin
              rd_ptr_q <= '0;
              state_q  <= auto_i ? ST_PLAY : ST_WSYNC;
            end
          end else if (sync_i) begin
            rd_ptr_q <= '0;
            state_q  <= ST_PLAY;
          end
        end
        ST_WSYNC: if (sync_i) begin
          rd_ptr_q <= '0;
          state_q  <= ST_PLAY;
        end
        ST_PLAY: if (fire) begin
          if (!at_end)        rd_ptr_q <= rd_ptr_q + 1'b1;
          else if (oneshot_i) state_q  <= ST_DONE;
          else                rd_ptr_q <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: write address steps by one between consecutive non-final beats
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_last_o && !soft_rst_i) |=> wr_addr_o == $past(wr_addr_o) + 1'b1);
  a_r7_no_write_in_play: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PLAY) |-> !wr_en_o);
  a_r9_done_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |-> !play_valid_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !soft_rst_i) |=> err_q);
  a_r12_soft_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (state_q == ST_IDLE && !err_q));
endmodule

// File: rtl/tx_replay_ctrl.sv
module tx_replay_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              init_req_i,
  output logic              init_ack_o,
  input  logic [1:0]        sync_mode_i,
  input  logic              hw_sync_i,
  input  logic              sw_sync_i,
  input  logic              oneshot_i,
  input  logic              bypass_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              m_ready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_last_o,
  output logic              empty_err_o,
  output logic [7:0]        state_o
);
  logic              auto_sel, sync_hit, load_ready, play_valid;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  tx_replay_sync u_sync (
    .mode_i   (sync_mode_i),
    .hw_sync_i(hw_sync_i),
    .sw_sync_i(sw_sync_i),
    .auto_o   (auto_sel),
    .sync_o   (sync_hit)
  );

  tx_replay_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .hold_i      (bypass_i),
    .init_req_i  (init_req_i),
    .auto_i      (auto_sel),
    .sync_i      (sync_hit),
    .oneshot_i   (oneshot_i),
    .beat_valid_i(s_valid_i),
    .beat_last_i (s_last_i),
    .rd_ready_i  (m_ready_i),
    .load_ready_o(load_ready),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_last_o   (wr_last_o),
    .rd_addr_o   (rd_addr),
    .play_valid_o(play_valid),
    .init_ack_o  (init_ack_o),
    .empty_err_o (empty_err_o),
    .state_o     (state_o)
  );

  tx_replay_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en_o),
    .waddr_i(wr_addr_o),
    .wdata_i(s_data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  assign wr_data_o = s_data_i;
  assign s_ready_o = bypass_i ? m_ready_i : load_ready;
  assign m_valid_o = bypass_i ? s_valid_i : play_valid;
  assign m_data_o  = bypass_i ? s_data_i  : rd_data;

  a_r11_bypass_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> !wr_en_o);
  a_r11_bypass_state_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bypass_i) && !$past(soft_rst_i)) |-> $stable(state_o));
endmodule

// File: tb/tx_replay_ctrl_bench.sv
`timescale 1ns/1ps
module tx_replay_ctrl_bench;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, init_req = 0, hw_sync = 0, sw_sync = 0, oneshot = 0, bypass = 0;
  logic [1:0] mode = 0;
  logic s_valid = 0, s_last = 0, m_ready = 0;
  logic [DW-1:0] s_data = 0;
  logic init_ack, s_ready, m_valid, wr_en, wr_last, empty_err;
  logic [DW-1:0] m_data, wr_data;
  logic [AW-1:0] wr_addr;
  logic [7:0] state;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tx_replay_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_tx_replay_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .init_req_i(init_req),
    .init_ack_o(init_ack), .sync_mode_i(mode), .hw_sync_i(hw_sync), .sw_sync_i(sw_sync),
    .oneshot_i(oneshot), .bypass_i(bypass), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_last_i(s_last), .s_ready_o(s_ready), .m_valid_o(m_valid), .m_data_o(m_data),
    .m_ready_i(m_ready), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_last_o(wr_last), .empty_err_o(empty_err), .state_o(state)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        one;
    logic [4:0]  len;
    logic [31:0] base;
    logic [7:0]  exp_state;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'd0, 1'b0, 5'd3, 32'h0000_0010, 8'd4},
    '{2'd0, 1'b1, 5'd4, 32'h0000_0020, 8'd4},
    '{2'd1, 1'b0, 5'd2, 32'h0000_0030, 8'd3},
    '{2'd2, 1'b1, 5'd5, 32'h0000_0040, 8'd3},
    '{2'd2, 1'b0, 5'd1, 32'h0000_0050, 8'd3},
    '{2'd1, 1'b1, 5'd1, 32'h0000_0060, 8'd3}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic soft_reset();
    @(negedge clk) soft_rst = 1;
    @(negedge clk) soft_rst = 0;
    #1 chk("R12 state idle", state, 0);
    chk("R12 flag clear", empty_err, 0);
  endtask

  task automatic do_init();
    @(negedge clk) init_req = 1;
    @(negedge clk) init_req = 0;
    #1 chk("R2 prepare", state, 1);
    chk("R2 ack low in prepare", init_ack, 0);
    @(negedge clk);
    #1 chk("R2 loading", state, 2);
    chk("R2 ack high", init_ack, 1);
  endtask

  task automatic load(int n, logic [31:0] base, bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = base + i; s_last = with_last && (i == n - 1);
      #1 chk("R3 ready", s_ready, 1);
      chk("R3 wr_en", wr_en, 1);
      chk("R3 wr_addr", wr_addr, i);
      chk("R3 wr_data", wr_data, base + i);
      chk("R3 wr_last", wr_last, (with_last && i == n - 1) || i == DEPTH - 1);
    end
    @(negedge clk) s_valid = 0; s_last = 0;
  endtask

  task automatic sync_pulse(bit hw, bit sw);
    @(negedge clk) hw_sync = hw; sw_sync = sw;
    @(negedge clk) hw_sync = 0; sw_sync = 0;
  endtask

  task automatic play_check(int n, logic [31:0] base, bit one);
    for (int k = 0; k < 2 * n + 2; k++) begin
      @(negedge clk) m_ready = 1;
      #1;
      if (one && k >= n) chk("R9 valid low after pass", m_valid, 0);
      else begin
        chk("R8 valid", m_valid, 1);
        chk("R8 data order", m_data, base + (k % n));
      end
    end
    @(negedge clk) m_ready = 0;
    #1 chk(one ? "R9 done" : "R8 still playing", state, one ? 5 : 4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 state", state, 0);
    chk("R1 ack", init_ack, 0);
    chk("R1 s_ready", s_ready, 0);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 flag", empty_err, 0);
    rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      soft_reset();
      mode = TBL[v].mode; oneshot = TBL[v].one;
      do_init();
      load(int'(TBL[v].len), TBL[v].base, 1);
      #1 chk(TBL[v].mode == 0 ? "R4 auto start" : "R5 wait sync", state, TBL[v].exp_state);
      if (TBL[v].mode != 0) begin
        chk("R5 ack held", init_ack, 1);
        s_valid = 1;
        #1 chk("R7 blocked in wait", s_ready, 0);
        s_valid = 0;
        sync_pulse(TBL[v].mode == 2, TBL[v].mode == 1);
        #1 chk("R5 wrong sync ignored", state, 3);
        sync_pulse(TBL[v].mode == 1, TBL[v].mode == 2);
        #1 chk("R5 sync starts play", state, 4);
      end
      s_valid = 1;
      #1 chk("R7 blocked in play", s_ready, 0);
      s_valid = 0;
      play_check(int'(TBL[v].len), TBL[v].base, TBL[v].one);
    end
    do_init();  // R2 re-entry from done

    // R6: hardware trigger mid-load refuses the concurrent beat
    soft_reset();
    mode = 1; oneshot = 0;
    do_init();
    load(3, 32'h100, 0);
    @(negedge clk) s_valid = 1; s_data = 32'hDEAD; hw_sync = 1;
    #1 chk("R6 beat refused", s_ready, 0);
    chk("R6 no write", wr_en, 0);
    @(negedge clk) s_valid = 0; hw_sync = 0;
    #1 chk("R6 playing", state, 4);
    play_check(3, 32'h100, 0);

    // R3: full buffer without last ends the load
    soft_reset();
    mode = 0;
    do_init();
    load(DEPTH, 32'h200, 0);
    #1 chk("R3 full ends load", state, 4);
    play_check(DEPTH, 32'h200, 0);

    // R10: read while empty
    soft_reset();
    mode = 1;
    do_init();
    sync_pulse(1, 0);
    #1 chk("R10 playing empty", state, 4);
    chk("R10 no valid", m_valid, 0);
    chk("R10 flag not yet", empty_err, 0);
    @(negedge clk) m_ready = 1;
    @(negedge clk) m_ready = 0;
    #1 chk("R10 flag set", empty_err, 1);
    repeat (3) @(negedge clk);
    #1 chk("R10 flag sticky", empty_err, 1);
    soft_reset();

    // R5: mode 3 never starts
    mode = 3;
    do_init();
    load(2, 32'h300, 1);
    #1 chk("R5 mode3 waits", state, 3);
    sync_pulse(1, 1);
    #1 chk("R5 mode3 no start", state, 3);

    // R11: bypass
    @(negedge clk) bypass = 1; s_valid = 1; s_data = 32'h1234; m_ready = 0;
    #1 chk("R11 valid follows", m_valid, 1);
    chk("R11 data follows", m_data, 32'h1234);
    chk("R11 ready follows low", s_ready, 0);
    chk("R11 no write", wr_en, 0);
    m_ready = 1;
    #1 chk("R11 ready follows high", s_ready, 1);
    hw_sync = 1;
    @(negedge clk) hw_sync = 0; s_valid = 0;
    #1 chk("R11 valid drops", m_valid, 0);
    chk("R11 state held", state, 3);
    bypass = 0; m_ready = 0;

    // R12: write address restarts after soft reset mid-load
    soft_reset();
    mode = 0;
    do_init();
    load(2, 32'h400, 0);
    soft_reset();
    do_init();
    load(1, 32'h500, 1);
    #1 chk("R12 reload starts", state, 4);
    play_check(1, 32'h500, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule